// File: doc/BRIEF.md
# Outbound Address Translation Unit

This block maps addresses seen on a local bus into the address space of a remote bus. It holds a small set of programmable windows. Each numbered window has a base address, a translation address and an attribute word. The attribute word carries an enable bit, a power-of-two size, a read transaction type, a write transaction type, a traffic class, and relaxed-ordering and no-snoop flags. Window 0 is the default window. It has no base address and catches any lookup that no numbered window claims.

A configuration port writes one register of one window per cycle. The lookup port takes a local address and a read/write flag. One clock later, the block returns the translated remote address, the index of the window that served the lookup, the transaction type to use, the traffic class and the two ordering flags. When no window serves the lookup, it returns a miss flag instead. In the translated address, the remote base replaces the address bits above the window size and the offset bits below it are kept.

Top module: `obx_xlate`

## Requirements
- R1: After synchronous reset every window is disabled, `rsp_valid` is low, and a lookup made before any programming returns a miss.
- R2: `rsp_valid` rises exactly one clock after a cycle with `lk_valid` high, and is low one clock after a cycle with `lk_valid` low.
- R3: A numbered window with size code N matches when the lookup address bits at and above position N+1 equal the same bits of its base. The translated address is the translation register with bits N..0 replaced by the lookup address bits N..0.
- R4: Register writes select the window with `cfg_win` (0 default, 1..NWIN numbered) and the register with `cfg_sel` (0 translation, 1 base, 2 attributes). The attribute word layout is: bit 0 enable, bit 1 relaxed ordering, bit 2 no snoop, bits 6:4 traffic class, bits 11:8 read type, bits 15:12 write type, bits 21:16 size code.
- R5: `rsp_ttype` is the window's write type when `lk_write` is high and its read type otherwise (codes 2 configuration, 4 memory, 8 I/O). `rsp_tc`, `rsp_ro` and `rsp_ns` come from the same window.
- R6: When several numbered windows match, the lowest-numbered one is reported.
- R7: A window whose enable bit is clear never matches.
- R8: A window with size code below 11 never matches, the default window included. A size code of ADDR_W-1 or more makes a numbered window cover the whole address space.
- R9: A lookup that no numbered window matches is served by the enabled default window, with `rsp_win` = 0 and its translation applied to the offset bits of its own size.
- R10: A lookup with no matching window and a disabled default window gives `rsp_miss` = 1, with address, window, type, class and flags all zero.
- R11: A base-register write to window 0 has no effect on any lookup result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_win | input | $clog2(NWIN+1) | Window selected for the write |
| cfg_sel | input | 2 | Register selected: 0 translation, 1 base, 2 attributes |
| cfg_data | input | ADDR_W | Write data |
| lk_valid | input | 1 | Lookup request |
| lk_write | input | 1 | Lookup is a write (1) or a read (0) |
| lk_addr | input | ADDR_W | Local address to translate |
| rsp_valid | output | 1 | Lookup result is valid |
| rsp_miss | output | 1 | No window served the lookup |
| rsp_win | output | $clog2(NWIN+1) | Serving window, 0 for default |
| rsp_addr | output | ADDR_W | Translated remote address |
| rsp_ttype | output | 4 | Transaction type code |
| rsp_tc | output | 3 | Traffic class |
| rsp_ro | output | 1 | Relaxed-ordering flag |
| rsp_ns | output | 1 | No-snoop flag |

## Verification
The offset property assumes that every serving window is at least 4 KiB. The block enforces this itself, so the property holds for any register contents. The window-range property assumes that `cfg_win` never addresses a window beyond NWIN. The stimulus writes only windows 0 to 4. The latency properties assume that `lk_valid` is driven to a known level in every cycle after reset. The bench drives it at each falling edge and holds it low between lookups. Each configuration write finishes before the next lookup starts, so no lookup meets a register that is changing in the same cycle.

// File: rtl/obx_pkg.sv
package obx_pkg;

    localparam int SIZE_W        = 6;
    localparam int TTYPE_W       = 4;
    localparam int TC_W          = 3;
    localparam int MIN_SIZE_CODE = 11;

    // register selector on the configuration port
    typedef enum logic [1:0] {
        SEL_XLAT = 2'd0,
        SEL_BASE = 2'd1,
        SEL_ATTR = 2'd2
    } cfg_sel_e;

    typedef struct packed {
        logic [SIZE_W-1:0]  size;
        logic [TTYPE_W-1:0] wtt;
        logic [TTYPE_W-1:0] rtt;
        logic [TC_W-1:0]    tc;
        logic               ns;
        logic               ro;
        logic               en;
    } attr_t;

    // attribute word: [0] en, [1] ro, [2] ns, [6:4] tc, [11:8] rtt,
    // [15:12] wtt, [21:16] size code
    function automatic attr_t unpack_attr(input logic [21:0] w);
        attr_t a;
        a.en   = w[0];
        a.ro   = w[1];
        a.ns   = w[2];
        a.tc   = w[6:4];
        a.rtt  = w[11:8];
        a.wtt  = w[15:12];
        a.size = w[21:16];
        return a;
    endfunction

endpackage

// File: rtl/obx_regs.sv
module obx_regs
    import obx_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NWIN   = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       we,
    input  logic [$clog2(NWIN+1)-1:0]  win,
    input  logic [1:0]                 sel,
    input  logic [ADDR_W-1:0]          data,
    output logic [ADDR_W-1:0]          xlat_o [NWIN+1],
    output logic [ADDR_W-1:0]          base_o [NWIN+1],
    output attr_t                      attr_o [NWIN+1]
);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i <= NWIN; i++) begin
                xlat_o[i] <= '0;
                base_o[i] <= '0;
                attr_o[i] <= '0;
            end
        end else if (we) begin
            for (int i = 0; i <= NWIN; i++) begin
                if (int'(win) == i) begin
                    unique case (cfg_sel_e'(sel))
                        SEL_XLAT: xlat_o[i] <= data;
                        // the default window owns no base register
                        SEL_BASE: if (i != 0) base_o[i] <= data;
                        SEL_ATTR: attr_o[i] <= unpack_attr(data[21:0]);
                        default:  ;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/obx_win_match.sv
module obx_win_match
    import obx_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter bit IS_DEFAULT = 1'b0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  attr_t             attr,
    output logic              hit,
    output logic [ADDR_W-1:0] keep_mask
);

    logic size_ok;
    logic base_eq;

    // size code N keeps offset bits N..0; codes past the width saturate
    always_comb begin
        for (int i = 0; i < ADDR_W; i++) begin
            keep_mask[i] = (i <= int'(attr.size));
        end
    end

    assign size_ok = (attr.size >= SIZE_W'(MIN_SIZE_CODE));

    generate
        if (IS_DEFAULT) begin : g_dflt
            assign base_eq = 1'b1;
        end else begin : g_num
            assign base_eq = (((addr ^ base) & ~keep_mask) == '0);
        end
    endgenerate

    assign hit = attr.en && size_ok && base_eq;

endmodule

// File: rtl/obx_select.sv
module obx_select #(
    parameter int NWIN = 4
) (
    input  logic [NWIN:0]               hit,
    output logic                        found,
    output logic [$clog2(NWIN+1)-1:0]   sel
);

    localparam int WIN_W = $clog2(NWIN + 1);

    // scan from the highest index down so the lowest numbered hit lands last
    always_comb begin
        found = hit[0];
        sel   = '0;
        for (int i = NWIN; i >= 1; i--) begin
            if (hit[i]) begin
                found = 1'b1;
                sel   = WIN_W'(i);
            end
        end
    end

endmodule

// File: rtl/obx_xlate.sv
module obx_xlate
    import obx_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NWIN   = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cfg_we,
    input  logic [$clog2(NWIN+1)-1:0]  cfg_win,
    input  logic [1:0]                 cfg_sel,
    input  logic [ADDR_W-1:0]          cfg_data,
    input  logic                       lk_valid,
    input  logic                       lk_write,
    input  logic [ADDR_W-1:0]          lk_addr,
    output logic                       rsp_valid,
    output logic                       rsp_miss,
    output logic [$clog2(NWIN+1)-1:0]  rsp_win,
    output logic [ADDR_W-1:0]          rsp_addr,
    output logic [3:0]                 rsp_ttype,
    output logic [2:0]                 rsp_tc,
    output logic                       rsp_ro,
    output logic                       rsp_ns
);

    localparam int WIN_W = $clog2(NWIN + 1);

    logic [ADDR_W-1:0] xlat_q [NWIN+1];
    logic [ADDR_W-1:0] base_q [NWIN+1];
    attr_t             attr_q [NWIN+1];
    logic [ADDR_W-1:0] mask_w [NWIN+1];
    logic [NWIN:0]     hit_w;
    logic              found;
    logic [WIN_W-1:0]  sel;

    attr_t             sel_attr;
    logic [ADDR_W-1:0] sel_mask;
    logic [ADDR_W-1:0] sel_xlat;

    obx_regs #(.ADDR_W(ADDR_W), .NWIN(NWIN)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_we),
        .win    (cfg_win),
        .sel    (cfg_sel),
        .data   (cfg_data),
        .xlat_o (xlat_q),
        .base_o (base_q),
        .attr_o (attr_q)
    );

    generate
        for (genvar w = 0; w <= NWIN; w++) begin : g_win
            obx_win_match #(.ADDR_W(ADDR_W), .IS_DEFAULT(w == 0)) u_match (
                .addr      (lk_addr),
                .base      (base_q[w]),
                .attr      (attr_q[w]),
                .hit       (hit_w[w]),
                .keep_mask (mask_w[w])
            );
        end
    endgenerate

    obx_select #(.NWIN(NWIN)) u_sel (
        .hit   (hit_w),
        .found (found),
        .sel   (sel)
    );

    always_comb begin
        sel_attr = attr_q[0];
        sel_mask = mask_w[0];
        sel_xlat = xlat_q[0];
        for (int i = 1; i <= NWIN; i++) begin
            if (int'(sel) == i) begin
                sel_attr = attr_q[i];
                sel_mask = mask_w[i];
                sel_xlat = xlat_q[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_win   <= '0;
            rsp_addr  <= '0;
            rsp_ttype <= '0;
            rsp_tc    <= '0;
            rsp_ro    <= 1'b0;
            rsp_ns    <= 1'b0;
        end else begin
            rsp_valid <= lk_valid;
            if (lk_valid) begin
                if (found) begin
                    rsp_miss  <= 1'b0;
                    rsp_win   <= sel;
                    rsp_addr  <= (sel_xlat & ~sel_mask) | (lk_addr & sel_mask);
                    rsp_ttype <= lk_write ? sel_attr.wtt : sel_attr.rtt;
                    rsp_tc    <= sel_attr.tc;
                    rsp_ro    <= sel_attr.ro;
                    rsp_ns    <= sel_attr.ns;
                end else begin
                    rsp_miss  <= 1'b1;
                    rsp_win   <= '0;
                    rsp_addr  <= '0;
                    rsp_ttype <= '0;
                    rsp_tc    <= '0;
                    rsp_ro    <= 1'b0;
                    rsp_ns    <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/obx_xlate_chk.sv
module obx_xlate_chk
    import obx_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NWIN   = 4
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       lk_valid,
    input logic [ADDR_W-1:0]          lk_addr,
    input logic                       rsp_valid,
    input logic                       rsp_miss,
    input logic [$clog2(NWIN+1)-1:0]  rsp_win,
    input logic [ADDR_W-1:0]          rsp_addr,
    input logic [3:0]                 rsp_ttype,
    input logic [2:0]                 rsp_tc
);

    localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((64'd1 << (MIN_SIZE_CODE + 1)) - 1);

    // R2: result appears one clock after a request
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> rsp_valid);

    // R2: no result without a request
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !rsp_valid);

    // R10: a miss carries no routing information
    a_r10_miss_zero: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_miss) |-> (rsp_addr == '0 && rsp_win == '0 &&
                                     rsp_ttype == '0 && rsp_tc == '0));

    // R6: reported window index is within range
    a_r6_win_range: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (int'(rsp_win) <= NWIN));

    // R3 and R8: every serving window is at least 4 KiB, so the low offset survives
    a_r3_offset_kept: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> (rsp_miss || ((rsp_addr ^ $past(lk_addr)) & LOW_MASK) == '0));

endmodule

bind obx_xlate obx_xlate_chk #(.ADDR_W(ADDR_W), .NWIN(NWIN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .lk_valid  (lk_valid),
    .lk_addr   (lk_addr),
    .rsp_valid (rsp_valid),
    .rsp_miss  (rsp_miss),
    .rsp_win   (rsp_win),
    .rsp_addr  (rsp_addr),
    .rsp_ttype (rsp_ttype),
    .rsp_tc    (rsp_tc)
);

// File: tb/tb_obx_xlate.sv
module tb_obx_xlate;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 32;
    localparam int NWIN       = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_win = '0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_data = '0;
    logic        lk_valid = 1'b0;
    logic        lk_write = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        rsp_valid, rsp_miss, rsp_ro, rsp_ns;
    logic [2:0]  rsp_win, rsp_tc;
    logic [31:0] rsp_addr;
    logic [3:0]  rsp_ttype;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    obx_xlate #(.ADDR_W(ADDR_W), .NWIN(NWIN)) dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_win(cfg_win),
        .cfg_sel(cfg_sel), .cfg_data(cfg_data), .lk_valid(lk_valid),
        .lk_write(lk_write), .lk_addr(lk_addr), .rsp_valid(rsp_valid),
        .rsp_miss(rsp_miss), .rsp_win(rsp_win), .rsp_addr(rsp_addr),
        .rsp_ttype(rsp_ttype), .rsp_tc(rsp_tc), .rsp_ro(rsp_ro), .rsp_ns(rsp_ns)
    );

    // attribute encoding taken from R4
    function automatic logic [31:0] mk_attr(input bit en, input bit ro, input bit ns,
                                            input int tc, input int rtt, input int wtt,
                                            input int sz);
        return 32'(en) | (32'(ro) << 1) | (32'(ns) << 2) | (32'(tc) << 4) |
               (32'(rtt) << 8) | (32'(wtt) << 12) | (32'(sz) << 16);
    endfunction

    task automatic wr(input int win, input int sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_win = 3'(win); cfg_sel = 2'(sel); cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic lookup(input logic [31:0] a, input bit w);
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a; lk_write = w;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic expect_hit(input string tag, input int win, input logic [31:0] a,
                              input int tt, input int tc, input bit ro, input bit ns);
        checks++;
        if (!(rsp_valid && !rsp_miss && int'(rsp_win) == win && rsp_addr == a &&
              int'(rsp_ttype) == tt && int'(rsp_tc) == tc && rsp_ro == ro && rsp_ns == ns)) begin
            errors++;
            $display("FAIL %s: got v=%0b miss=%0b win=%0d addr=%h tt=%0d tc=%0d ro=%0b ns=%0b, expected v=1 miss=0 win=%0d addr=%h tt=%0d tc=%0d ro=%0b ns=%0b",
                     tag, rsp_valid, rsp_miss, rsp_win, rsp_addr, rsp_ttype, rsp_tc, rsp_ro, rsp_ns,
                     win, a, tt, tc, ro, ns);
        end
    endtask

    task automatic expect_miss(input string tag);
        checks++;
        if (!(rsp_valid && rsp_miss && rsp_win == 0 && rsp_addr == 0 && rsp_ttype == 0 &&
              rsp_tc == 0 && !rsp_ro && !rsp_ns)) begin
            errors++;
            $display("FAIL %s: got v=%0b miss=%0b win=%0d addr=%h tt=%0d tc=%0d, expected v=1 miss=1 and zero fields",
                     tag, rsp_valid, rsp_miss, rsp_win, rsp_addr, rsp_ttype, rsp_tc);
        end
    endtask

    task automatic t_reset;
        checks++;
        if (rsp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1: rsp_valid=%0b after reset, expected 0", rsp_valid);
        end
        lookup(32'h0000_0000, 1'b0);
        expect_miss("R1 lookup after reset");
    endtask

    task automatic t_idle;
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R2: rsp_valid=%0b with no request, expected 0", rsp_valid);
        end
    endtask

    task automatic t_basic;
        wr(1, 0, 32'h1234_0000);
        wr(1, 1, 32'h8000_0000);
        wr(1, 2, mk_attr(1, 1, 0, 5, 4, 8, 15));
        lookup(32'h8000_ABCD, 1'b0);
        expect_hit("R3 window 1 read", 1, 32'h1234_ABCD, 4, 5, 1, 0);
        lookup(32'h8000_ABCD, 1'b1);
        expect_hit("R5 window 1 write type", 1, 32'h1234_ABCD, 8, 5, 1, 0);
        lookup(32'h8001_0000, 1'b0);
        expect_miss("R10 outside window, default off");
    endtask

    task automatic t_default;
        wr(0, 0, 32'hF000_0000);
        wr(0, 2, mk_attr(1, 0, 1, 0, 2, 2, 27));
        lookup(32'h9000_1234, 1'b0);
        expect_hit("R9 default window", 0, 32'hF000_1234, 2, 0, 0, 1);
    endtask

    task automatic t_priority;
        wr(2, 0, 32'h4000_0000);
        wr(2, 1, 32'h8000_0000);
        wr(2, 2, mk_attr(1, 0, 0, 3, 4, 4, 19));
        lookup(32'h8000_1000, 1'b0);
        expect_hit("R6 lowest window wins", 1, 32'h1234_1000, 4, 5, 1, 0);
        lookup(32'h8001_0000, 1'b1);
        expect_hit("R3 window 2 larger size", 2, 32'h4001_0000, 4, 3, 0, 0);
    endtask

    task automatic t_disable;
        wr(1, 2, mk_attr(0, 1, 0, 5, 4, 8, 15));
        lookup(32'h8000_1000, 1'b0);
        expect_hit("R7 disabled window skipped", 2, 32'h4000_1000, 4, 3, 0, 0);
    endtask

    task automatic t_size;
        wr(3, 0, 32'h3000_0000);
        wr(3, 1, 32'h2000_0000);
        wr(3, 2, mk_attr(1, 0, 0, 1, 8, 8, 10));
        lookup(32'h2000_0010, 1'b0);
        expect_hit("R8 size code 10 never matches", 0, 32'hF000_0010, 2, 0, 0, 1);
        wr(3, 2, mk_attr(1, 0, 0, 1, 8, 8, 11));
        lookup(32'h2000_0010, 1'b0);
        expect_hit("R8 size code 11 matches", 3, 32'h3000_0010, 8, 1, 0, 0);
        lookup(32'h2000_1010, 1'b0);
        expect_hit("R8 4 KiB boundary", 0, 32'hF000_1010, 2, 0, 0, 1);
    endtask

    task automatic t_base0;
        wr(0, 1, 32'h9000_0000);
        lookup(32'h9000_1234, 1'b0);
        expect_hit("R11 base write to window 0", 0, 32'hF000_1234, 2, 0, 0, 1);
    endtask

    task automatic t_full;
        wr(4, 0, 32'hABCD_0000);
        wr(4, 2, mk_attr(1, 0, 0, 7, 4, 4, 63));
        lookup(32'h5555_5555, 1'b0);
        expect_hit("R8 full space window", 4, 32'h5555_5555, 4, 7, 0, 0);
        lookup(32'h2000_0010, 1'b1);
        expect_hit("R6 window 3 over window 4", 3, 32'h3000_0010, 8, 1, 0, 0);
        wr(4, 2, mk_attr(0, 0, 0, 7, 4, 4, 63));
        wr(0, 2, mk_attr(0, 0, 1, 0, 2, 2, 27));
        lookup(32'h9000_0000, 1'b0);
        expect_miss("R10 all off");
        wr(0, 2, mk_attr(1, 0, 1, 0, 2, 2, 27));
        lookup(32'h9000_0000, 1'b1);
        expect_hit("R4 default re-enabled", 0, 32'hF000_0000, 2, 0, 0, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_idle();
        t_basic();
        t_default();
        t_priority();
        t_disable();
        t_size();
        t_base0();
        t_full();
        t_idle();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: run did not finish, expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule